// File: doc/BRIEF.md
# Streaming Load Line Buffer

This block serves 16-byte streaming loads that carry a non-temporal hint. When such a load targets a write-combining region, the block fetches the whole aligned 64-byte line into one private line buffer and nothing is placed in a cache. In the same cycle it issues a snoop request that removes any cached alias of that line. Later streaming loads to chunks of that line that have not yet been handed out are answered from the buffer, with no memory access.

Each chunk of the held line is handed out only once. Any of the following discards the held line, and the load that caused it goes to memory: a second read of a chunk, an ordinary load to the line, an access to the line tagged with a non-WC type, an observed store to the line, or an external flush. A streaming load to a region that is not WC is served as an ordinary 16-byte load. A misaligned address raises a fault and returns no data. Only one memory fetch may be outstanding. New requests are stalled from acceptance until the response handshake.

Top module: `stream_line_buf`

## Requirements
- R1: A request whose address has any of bits [3:0] set produces a one-cycle `fault_o` pulse in the cycle after acceptance. It produces no response and no memory request.
- R2: A streaming load with memory type WC (`req_mtype_i` = 2'b01) that does not hit an unread chunk issues a memory request with `mem_req_line_o` = 1 and the address with bits [5:0] cleared. Its response is chunk `addr[5:4]` of the returned line, where chunk i occupies bits [128*i +: 128].
- R3: A line request is accompanied by `snoop_valid_o` for exactly its first cycle, with `snoop_addr_o` equal to the line address. Chunk requests raise no snoop.
- R4: A WC streaming load to an unread chunk of the held line is answered in the cycle after acceptance, with no memory request.
- R5: A WC streaming load to a chunk of the held line that has already been read discards the line and is handled as a fresh line fetch.
- R6: A non-streaming load is served by a chunk request (`mem_req_line_o` = 0, address with bits [3:0] cleared; the data is taken from bits [127:0]). If it touches the held line, the line is discarded.
- R7: A streaming load to the held line with a type other than WC is served as a chunk request and discards the held line.
- R8: A store observed on `st_valid_i` to the held line discards it. A store to any other line leaves it usable.
- R9: A non-WC streaming load to a different line is served as a chunk request and leaves the held line usable.
- R10: `flush_i` discards the held line from the next cycle. A flush in the same cycle as a would-be hit turns that load into a line fetch.
- R11: `req_ready_o` is low from acceptance until the response handshake. The response data stays stable while `rsp_ready_i` is low.
- R12: Each line fill clears the read marks, leaving only the chunk returned by the filling load marked as read.
- R13: A flush, or a store to the line being fetched, that arrives while a line fetch is pending still lets the load complete, but the line is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Load request accepted |
| req_addr_i | input | 32 | Load byte address |
| req_mtype_i | input | 2 | Memory type: 0 UC, 1 WC, 2 WT, 3 WB |
| req_stream_i | input | 1 | Non-temporal hint |
| st_valid_i | input | 1 | Observed store valid |
| st_addr_i | input | 32 | Observed store address |
| flush_i | input | 1 | External buffer flush |
| mem_req_valid_o | output | 1 | Memory fetch request valid |
| mem_req_ready_i | input | 1 | Memory fetch request accepted |
| mem_req_addr_o | output | 32 | Fetch address (line or chunk aligned) |
| mem_req_line_o | output | 1 | 1: whole line, 0: one chunk |
| mem_rsp_valid_i | input | 1 | Fetch data valid |
| mem_rsp_data_i | input | 512 | Fetch data |
| snoop_valid_o | output | 1 | Snoop/flush request for an aliased line |
| snoop_addr_o | output | 32 | Snooped line address |
| rsp_valid_o | output | 1 | Load response valid |
| rsp_ready_i | input | 1 | Load response accepted |
| rsp_data_o | output | 128 | Load data |
| fault_o | output | 1 | Misalignment fault pulse |

## Verification
Two things can meet in one cycle. A flush can land on the same edge as a streaming load that would otherwise hit. A store or flush can land while a line fetch is still outstanding. The bench provokes the first by raising `flush_i` together with `req_valid_i`, and expects a line fetch instead of a buffer answer. It provokes the second by pulsing a store to the pending line between the fetch handshake and the returned data. It judges that case by requiring the load's data to arrive correctly and the next load to that line to fetch again.

// File: rtl/slb_pkg.sv
package slb_pkg;
  typedef enum logic [1:0] {
    MT_UC = 2'd0,
    MT_WC = 2'd1,
    MT_WT = 2'd2,
    MT_WB = 2'd3
  } mtype_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_RESP
  } state_e;
endpackage

// File: rtl/slb_lookup.sv
module slb_lookup
  import slb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 16,
  localparam int N_CHUNK = LINE_BYTES / CHUNK_BYTES,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int COFF_W  = $clog2(CHUNK_BYTES),
  localparam int CIDX_W  = OFF_W - COFF_W,
  localparam int TAG_W   = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_mtype_i,
  input  logic               req_stream_i,
  input  logic               st_valid_i,
  input  logic [ADDR_W-1:0]  st_addr_i,
  input  logic               flush_i,
  input  logic               buf_valid_i,
  input  logic [TAG_W-1:0]   buf_tag_i,
  input  logic [N_CHUNK-1:0] read_mask_i,
  output logic               misaligned_o,
  output logic [TAG_W-1:0]   req_tag_o,
  output logic [CIDX_W-1:0]  chunk_idx_o,
  output logic               wc_stream_o,
  output logic               touch_o,
  output logic               kill_o,
  output logic               serve_o,
  output logic [TAG_W-1:0]   st_tag_o
);
  logic unused_st_low;
  assign unused_st_low = ^st_addr_i[OFF_W-1:0];

  assign misaligned_o = |req_addr_i[COFF_W-1:0];
  assign req_tag_o    = req_addr_i[ADDR_W-1:OFF_W];
  assign chunk_idx_o  = req_addr_i[OFF_W-1:COFF_W];
  assign st_tag_o     = st_addr_i[ADDR_W-1:OFF_W];
  assign wc_stream_o  = req_stream_i && (mtype_e'(req_mtype_i) == MT_WC);
  assign touch_o      = buf_valid_i && (buf_tag_i == req_tag_o);
  // flush or store to the held line wins over a hit in the same cycle
  assign kill_o       = flush_i || (st_valid_i && buf_valid_i && (st_tag_o == buf_tag_i));
  assign serve_o      = wc_stream_o && touch_o && !kill_o && !misaligned_o
                        && !read_mask_i[chunk_idx_o];
endmodule

// File: rtl/slb_line_store.sv
module slb_line_store #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 16,
  localparam int N_CHUNK = LINE_BYTES / CHUNK_BYTES,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int COFF_W  = $clog2(CHUNK_BYTES),
  localparam int CIDX_W  = OFF_W - COFF_W,
  localparam int TAG_W   = ADDR_W - OFF_W,
  localparam int CHUNK_W = CHUNK_BYTES * 8,
  localparam int LINE_W  = LINE_BYTES * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fill_i,
  input  logic [TAG_W-1:0]   fill_tag_i,
  input  logic [LINE_W-1:0]  fill_data_i,
  input  logic [CIDX_W-1:0]  fill_idx_i,
  input  logic               inv_i,
  input  logic               mark_i,
  input  logic [CIDX_W-1:0]  mark_idx_i,
  input  logic [CIDX_W-1:0]  rd_idx_i,
  output logic               valid_o,
  output logic [TAG_W-1:0]   tag_o,
  output logic [N_CHUNK-1:0] read_mask_o,
  output logic [CHUNK_W-1:0] rd_data_o
);
  logic [N_CHUNK-1:0][CHUNK_W-1:0] data_w;

  for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
    logic [CHUNK_W-1:0] q;
    always_ff @(posedge clk_i) begin
      if (fill_i) q <= fill_data_i[g*CHUNK_W +: CHUNK_W];
    end
    assign data_w[g] = q;
  end

  assign rd_data_o = data_w[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      tag_o       <= '0;
      read_mask_o <= '0;
    end else if (inv_i) begin
      valid_o     <= 1'b0;
      read_mask_o <= '0;
    end else if (fill_i) begin
      valid_o     <= 1'b1;
      tag_o       <= fill_tag_i;
      read_mask_o <= N_CHUNK'(1) << fill_idx_i;
    end else if (mark_i) begin
      read_mask_o[mark_idx_i] <= 1'b1;
    end
  end

  AST_INV_DROPS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> !valid_o); // R10
  AST_FILL_RESETS_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !inv_i |=> valid_o && (read_mask_o == (N_CHUNK'(1) << $past(fill_idx_i)))); // R12
  AST_MARK_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_i && !inv_i && !fill_i |=> read_mask_o[$past(mark_idx_i)]); // R4
endmodule

// File: rtl/slb_ctrl.sv
module slb_ctrl
  import slb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 16,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int COFF_W  = $clog2(CHUNK_BYTES),
  localparam int CIDX_W  = OFF_W - COFF_W,
  localparam int TAG_W   = ADDR_W - OFF_W,
  localparam int CHUNK_W = CHUNK_BYTES * 8,
  localparam int LINE_W  = LINE_BYTES * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               misaligned_i,
  input  logic               serve_i,
  input  logic               wc_stream_i,
  input  logic               touch_i,
  input  logic               kill_i,
  input  logic [TAG_W-1:0]   req_tag_i,
  input  logic [CIDX_W-1:0]  chunk_idx_i,
  input  logic               st_valid_i,
  input  logic [TAG_W-1:0]   st_tag_i,
  input  logic               flush_i,
  input  logic [CHUNK_W-1:0] buf_rd_data_i,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [ADDR_W-1:0]  mem_req_addr_o,
  output logic               mem_req_line_o,
  input  logic               mem_rsp_valid_i,
  input  logic [LINE_W-1:0]  mem_rsp_data_i,
  output logic               snoop_valid_o,
  output logic [ADDR_W-1:0]  snoop_addr_o,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [CHUNK_W-1:0] rsp_data_o,
  output logic               fault_o,
  output logic               fill_o,
  output logic [TAG_W-1:0]   fill_tag_o,
  output logic [CIDX_W-1:0]  fill_idx_o,
  output logic               inv_o,
  output logic               mark_o,
  output logic [CIDX_W-1:0]  mark_idx_o
);
  state_e             state_q;
  logic [TAG_W-1:0]   pend_tag_q;
  logic [CIDX_W-1:0]  pend_idx_q;
  logic               pend_line_q;
  logic               poison_q;
  logic               snoop_q;
  logic               fault_q;
  logic [CHUNK_W-1:0] rsp_data_q;
  logic               accept;
  logic               conflict;
  logic               fetch_active;
  logic [CHUNK_W-1:0] mem_chunk;

  assign accept       = req_valid_i && (state_q == S_IDLE);
  assign fetch_active = (state_q == S_FETCH) || (state_q == S_WAIT);
  // a conflict during a pending line fetch keeps the line from being held
  assign conflict     = flush_i || (st_valid_i && (st_tag_i == pend_tag_q));
  assign mem_chunk    = pend_line_q ? mem_rsp_data_i[int'(pend_idx_q)*CHUNK_W +: CHUNK_W]
                                    : mem_rsp_data_i[CHUNK_W-1:0];

  assign req_ready_o     = (state_q == S_IDLE);
  assign mem_req_valid_o = (state_q == S_FETCH);
  assign mem_req_line_o  = pend_line_q;
  assign mem_req_addr_o  = pend_line_q ? {pend_tag_q, {OFF_W{1'b0}}}
                                       : {pend_tag_q, pend_idx_q, {COFF_W{1'b0}}};
  assign snoop_valid_o   = snoop_q;
  assign snoop_addr_o    = {pend_tag_q, {OFF_W{1'b0}}};
  assign rsp_valid_o     = (state_q == S_RESP);
  assign rsp_data_o      = rsp_data_q;
  assign fault_o         = fault_q;

  assign inv_o      = kill_i || (accept && !misaligned_i && !serve_i && (touch_i || wc_stream_i));
  assign mark_o     = accept && serve_i;
  assign mark_idx_o = chunk_idx_i;
  assign fill_o     = (state_q == S_WAIT) && mem_rsp_valid_i && pend_line_q
                      && !poison_q && !conflict;
  assign fill_tag_o = pend_tag_q;
  assign fill_idx_o = pend_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      pend_tag_q  <= '0;
      pend_idx_q  <= '0;
      pend_line_q <= 1'b0;
      poison_q    <= 1'b0;
      snoop_q     <= 1'b0;
      fault_q     <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      snoop_q <= 1'b0;
      fault_q <= 1'b0;
      if (fetch_active && conflict) poison_q <= 1'b1;
      unique case (state_q)
        S_IDLE: if (accept) begin
          if (misaligned_i) begin
            fault_q <= 1'b1;
          end else if (serve_i) begin
            rsp_data_q <= buf_rd_data_i;
            state_q    <= S_RESP;
          end else begin
            pend_tag_q  <= req_tag_i;
            pend_idx_q  <= chunk_idx_i;
            pend_line_q <= wc_stream_i;
            poison_q    <= 1'b0;
            snoop_q     <= wc_stream_i;
            state_q     <= S_FETCH;
          end
        end
        S_FETCH: if (mem_req_ready_i) state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid_i) begin
          rsp_data_q <= mem_chunk;
          state_q    <= S_RESP;
        end
        S_RESP: if (rsp_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_FAULT_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !rsp_valid_o && !mem_req_valid_o); // R1
  AST_LINE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_line_o |-> mem_req_addr_o[OFF_W-1:0] == '0); // R2
  AST_SNOOP_WITH_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_valid_o |-> mem_req_valid_o && mem_req_line_o && (snoop_addr_o == mem_req_addr_o)); // R3
  AST_SNOOP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_valid_o |=> !snoop_valid_o); // R3
  AST_SINGLE_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o); // R11
  AST_RSP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o)); // R11
endmodule

// File: rtl/stream_line_buf.sv
module stream_line_buf #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 16,
  localparam int N_CHUNK = LINE_BYTES / CHUNK_BYTES,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int COFF_W  = $clog2(CHUNK_BYTES),
  localparam int CIDX_W  = OFF_W - COFF_W,
  localparam int TAG_W   = ADDR_W - OFF_W,
  localparam int CHUNK_W = CHUNK_BYTES * 8,
  localparam int LINE_W  = LINE_BYTES * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_mtype_i,
  input  logic               req_stream_i,
  input  logic               st_valid_i,
  input  logic [ADDR_W-1:0]  st_addr_i,
  input  logic               flush_i,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [ADDR_W-1:0]  mem_req_addr_o,
  output logic               mem_req_line_o,
  input  logic               mem_rsp_valid_i,
  input  logic [LINE_W-1:0]  mem_rsp_data_i,
  output logic               snoop_valid_o,
  output logic [ADDR_W-1:0]  snoop_addr_o,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [CHUNK_W-1:0] rsp_data_o,
  output logic               fault_o
);
  logic               buf_valid;
  logic [TAG_W-1:0]   buf_tag;
  logic [N_CHUNK-1:0] read_mask;
  logic [CHUNK_W-1:0] buf_rd_data;
  logic               misaligned, wc_stream, touch, kill, serve;
  logic [TAG_W-1:0]   req_tag, st_tag, fill_tag;
  logic [CIDX_W-1:0]  chunk_idx, fill_idx, mark_idx;
  logic               fill, inv, mark;

  slb_lookup #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CHUNK_BYTES(CHUNK_BYTES)) u_lookup (
    .req_addr_i   (req_addr_i),
    .req_mtype_i  (req_mtype_i),
    .req_stream_i (req_stream_i),
    .st_valid_i   (st_valid_i),
    .st_addr_i    (st_addr_i),
    .flush_i      (flush_i),
    .buf_valid_i  (buf_valid),
    .buf_tag_i    (buf_tag),
    .read_mask_i  (read_mask),
    .misaligned_o (misaligned),
    .req_tag_o    (req_tag),
    .chunk_idx_o  (chunk_idx),
    .wc_stream_o  (wc_stream),
    .touch_o      (touch),
    .kill_o       (kill),
    .serve_o      (serve),
    .st_tag_o     (st_tag)
  );

  slb_line_store #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CHUNK_BYTES(CHUNK_BYTES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_i      (fill),
    .fill_tag_i  (fill_tag),
    .fill_data_i (mem_rsp_data_i),
    .fill_idx_i  (fill_idx),
    .inv_i       (inv),
    .mark_i      (mark),
    .mark_idx_i  (mark_idx),
    .rd_idx_i    (chunk_idx),
    .valid_o     (buf_valid),
    .tag_o       (buf_tag),
    .read_mask_o (read_mask),
    .rd_data_o   (buf_rd_data)
  );

  slb_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CHUNK_BYTES(CHUNK_BYTES)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .misaligned_i    (misaligned),
    .serve_i         (serve),
    .wc_stream_i     (wc_stream),
    .touch_i         (touch),
    .kill_i          (kill),
    .req_tag_i       (req_tag),
    .chunk_idx_i     (chunk_idx),
    .st_valid_i      (st_valid_i),
    .st_tag_i        (st_tag),
    .flush_i         (flush_i),
    .buf_rd_data_i   (buf_rd_data),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_line_o  (mem_req_line_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .snoop_valid_o   (snoop_valid_o),
    .snoop_addr_o    (snoop_addr_o),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .rsp_data_o      (rsp_data_o),
    .fault_o         (fault_o),
    .fill_o          (fill),
    .fill_tag_o      (fill_tag),
    .fill_idx_o      (fill_idx),
    .inv_o           (inv),
    .mark_o          (mark),
    .mark_idx_o      (mark_idx)
  );

  AST_HIT_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && serve |=> rsp_valid_o && !mem_req_valid_o); // R4
endmodule

// File: tb/stream_line_buf_tb_top.sv
`timescale 1ns/1ps
module stream_line_buf_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [31:0]  req_addr_i = '0;
  logic [1:0]   req_mtype_i = '0;
  logic         req_stream_i = 1'b0;
  logic         st_valid_i = 1'b0;
  logic [31:0]  st_addr_i = '0;
  logic         flush_i = 1'b0;
  logic         mem_req_valid_o;
  logic         mem_req_ready_i = 1'b0;
  logic [31:0]  mem_req_addr_o;
  logic         mem_req_line_o;
  logic         mem_rsp_valid_i = 1'b0;
  logic [511:0] mem_rsp_data_i = '0;
  logic         snoop_valid_o;
  logic [31:0]  snoop_addr_o;
  logic         rsp_valid_o;
  logic         rsp_ready_i = 1'b0;
  logic [127:0] rsp_data_o;
  logic         fault_o;

  int n_run = 0;
  int n_fail = 0;
  bit done_flag = 0;

  // reference state of the held line
  bit        mv = 0;
  bit [25:0] mtag = '0;
  bit [3:0]  mread = '0;

  always #10 clk_i = ~clk_i;

  stream_line_buf dut_i (.*);

  function automatic logic [127:0] chunk_of(input logic [31:0] a);
    logic [31:0] b;
    b = {a[31:4], 4'h0};
    return {b ^ 32'hA5A5_0000, ~b, b * 32'd3 + 32'd1, b[15:0], 16'h5A3C};
  endfunction

  function automatic logic [511:0] line_of(input logic [31:0] a);
    logic [511:0] l;
    for (int i = 0; i < 4; i++) l[i*128 +: 128] = chunk_of({a[31:6], 6'h0} + 32'(i * 16));
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_store(input logic [31:0] a);
    @(negedge clk_i);
    st_valid_i = 1'b1; st_addr_i = a;
    @(negedge clk_i);
    st_valid_i = 1'b0;
    if (mv && a[31:6] == mtag) mv = 0;
  endtask

  task automatic do_flush();
    @(negedge clk_i);
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
    mv = 0;
  endtask

  task automatic do_load(input logic [31:0] a, input logic [1:0] mt, input bit st,
                         input bit fl, input bit st_dur, input string tag);
    bit mis, hit, wcs, exp_mem, exp_line, got_mem;
    logic [31:0] exp_addr, maddr;
    logic [127:0] exp_data, got;
    int extra_snoop;
    mis = (a[3:0] != 4'h0);
    hit = mv && (a[31:6] == mtag) && !fl;
    wcs = st && (mt == 2'd1);
    if (fl) mv = 0;
    exp_mem = 0; exp_line = 0; exp_addr = '0;
    if (!mis) begin
      if (wcs && hit && !mread[a[5:4]]) begin
        mread[a[5:4]] = 1'b1;
      end else if (wcs) begin
        exp_mem = 1; exp_line = 1; exp_addr = {a[31:6], 6'h0};
        mtag = a[31:6]; mread = 4'b0001 << a[5:4]; mv = !st_dur;
      end else begin
        exp_mem = 1; exp_addr = {a[31:4], 4'h0};
        if (mv && a[31:6] == mtag) mv = 0;
      end
    end
    exp_data = chunk_of(a);

    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_mtype_i = mt; req_stream_i = st; flush_i = fl;
    @(negedge clk_i);
    req_valid_i = 1'b0; flush_i = 1'b0;

    if (mis) begin
      chk(fault_o && !rsp_valid_o && !mem_req_valid_o, "R1", "fault without data",
          {125'd0, fault_o, rsp_valid_o, mem_req_valid_o}, 128'd4);
      return;
    end
    chk(!fault_o, "R1", "no fault on aligned address", 128'(fault_o), 128'd0);
    got_mem = mem_req_valid_o;
    chk(got_mem == exp_mem, tag, "memory request issued", 128'(got_mem), 128'(exp_mem));
    if (got_mem) begin
      maddr = mem_req_addr_o;
      chk(mem_req_line_o == exp_line, tag, "line flag", 128'(mem_req_line_o), 128'(exp_line));
      chk(maddr == exp_addr, exp_line ? "R2" : "R6", "fetch address", 128'(maddr), 128'(exp_addr));
      chk(snoop_valid_o == mem_req_line_o && (!mem_req_line_o || snoop_addr_o == maddr),
          "R3", "snoop with line request", {95'd0, snoop_valid_o, snoop_addr_o}, {95'd0, exp_line, exp_addr});
      chk(!req_ready_o, "R11", "stall while fetching", 128'(req_ready_o), 128'd0);
      extra_snoop = 0;
      repeat ($urandom % 3) begin
        @(negedge clk_i);
        if (snoop_valid_o) extra_snoop++;
      end
      mem_req_ready_i = 1'b1;
      @(negedge clk_i);
      mem_req_ready_i = 1'b0;
      if (snoop_valid_o) extra_snoop++;
      chk(extra_snoop == 0, "R3", "snoop lasts one cycle", 128'(extra_snoop), 128'd0);
      if (st_dur && mem_req_line_o) begin
        st_valid_i = 1'b1; st_addr_i = maddr + 32'h20;
        @(negedge clk_i);
        st_valid_i = 1'b0;
      end
      repeat ($urandom % 3) @(negedge clk_i);
      mem_rsp_valid_i = 1'b1;
      mem_rsp_data_i = mem_req_line_o ? line_of(maddr) : {~line_of(maddr)} ^ {384'd0, ~chunk_of(maddr) ^ chunk_of(maddr) ^ ~line_of(maddr)[127:0]};
      if (!mem_req_line_o) mem_rsp_data_i[127:0] = chunk_of(maddr);
      @(negedge clk_i);
      mem_rsp_valid_i = 1'b0;
    end
    chk(rsp_valid_o, got_mem ? "R11" : "R4", "response valid", 128'(rsp_valid_o), 128'd1);
    if (!rsp_valid_o) return;
    chk(!req_ready_o, "R11", "stall until response taken", 128'(req_ready_o), 128'd0);
    got = rsp_data_o;
    repeat ($urandom % 3) begin
      @(negedge clk_i);
      chk(rsp_valid_o && rsp_data_o == got, "R11", "response held", rsp_data_o, got);
    end
    chk(got == exp_data, exp_line ? "R2" : (exp_mem ? "R6" : "R4"), "load data", got, exp_data);
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done_flag) begin
      done_flag = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o && !mem_req_valid_o && !fault_o && !snoop_valid_o,
        "R11", "reset state", {123'd0, req_ready_o, rsp_valid_o, mem_req_valid_o, fault_o, snoop_valid_o},
        128'h10);

    do_load(32'h1000, 2'd1, 1, 0, 0, "R2");   // miss, line fill
    do_load(32'h1010, 2'd1, 1, 0, 0, "R4");   // unread chunk hit
    do_load(32'h1030, 2'd1, 1, 0, 0, "R4");
    do_load(32'h1010, 2'd1, 1, 0, 0, "R5");   // repeated chunk refetches
    do_load(32'h1020, 2'd1, 1, 0, 0, "R12");  // marks cleared by refill
    do_load(32'h1000, 2'd1, 0, 0, 0, "R6");   // ordinary load to held line
    do_load(32'h1030, 2'd1, 1, 0, 0, "R6");   // line was dropped
    do_load(32'h1000, 2'd3, 1, 0, 0, "R7");   // non-WC type to held line
    do_load(32'h1010, 2'd1, 1, 0, 0, "R7");   // line was dropped
    do_load(32'h2000, 2'd3, 1, 0, 0, "R9");   // non-WC elsewhere
    do_load(32'h1020, 2'd1, 1, 0, 0, "R9");   // still held
    do_store(32'h2040);
    do_load(32'h1030, 2'd1, 1, 0, 0, "R8");   // store elsewhere: still held
    do_store(32'h1008);
    do_load(32'h1000, 2'd1, 1, 0, 0, "R8");   // store to line dropped it
    do_flush();
    do_load(32'h1010, 2'd1, 1, 0, 0, "R10");
    do_load(32'h1020, 2'd1, 1, 1, 0, "R10");  // flush with would-be hit
    do_load(32'h1008, 2'd1, 1, 0, 0, "R1");   // misaligned
    do_load(32'h1030, 2'd1, 1, 0, 0, "R1");   // buffer untouched by fault
    do_load(32'h3000, 2'd1, 1, 0, 1, "R13");  // store during pending fill
    do_load(32'h3010, 2'd1, 1, 0, 0, "R13");  // must refetch

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      logic [1:0] mt;
      int r;
      a = 32'h4000 + 32'(($urandom % 3) * 64) + 32'(($urandom % 4) * 16);
      if ($urandom % 12 == 0) a = a + 32'(($urandom % 15) + 1);
      mt = ($urandom % 2 == 0) ? 2'd1 : 2'($urandom % 4);
      do_load(a, mt, ($urandom % 4) != 0, ($urandom % 16) == 0, ($urandom % 10) == 0, "R2");
      r = $urandom % 20;
      if (r < 2) do_store(32'h4000 + 32'(($urandom % 3) * 64) + 32'(($urandom % 64)));
      else if (r == 2) do_flush();
    end

    repeat (2) @(negedge clk_i);
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule